// File: doc/BRIEF.md
# Min-Max Peak Detect Capture Unit

The unit sits between a sample converter and acquisition memory. On every convert strobe it buffers one data byte, then one clock later loads a pair of lane registers, a low lane and a high lane. How the lanes are loaded depends on the acquisition mode. Plain sampling splits alternating samples between the lanes. X-Y pairing puts channel-1 samples in the low lane and channel-2 samples in the high lane. Peak detection keeps the lowest and highest byte seen during each save period.

Save periods are marked by a one-cycle save strobe. Each strobe closes the running period and opens the next. When a period closes, the lane contents are copied to the output pins and a one-cycle valid pulse is raised. A test input swaps the converter byte for a host-supplied diagnostic byte, so the lane path can be exercised without a converter. The convert and save timing arrive as clock enables in a single clock domain.

Top module: `peak_capture`

## Requirements
- R1: A byte is taken into the input buffer in the cycle where conv_en_i is high. The lanes are updated from that byte one clock later, so a sample converted in the cycle just before a save strobe is included in the emitted pair.
- R2: While test_i is high, the buffered byte is taken from diag_i and adc_i is ignored. While test_i is low, the byte is taken from adc_i.
- R3: Sampling mode (mode_i 00, and the reserved code 11 behaves the same) restarts the even/odd count at the first sample of each save period. Even samples (0, 2, …) load the low lane and odd samples load the high lane.
- R4: X-Y mode (mode_i 01) loads the low lane with channel 1 (even phase) and the high lane with channel 2 (odd phase). The channel phase runs on across save periods and is not restarted by a save strobe.
- R5: Peak mode (mode_i 10) loads the first sample of each save period into both lanes at once.
- R6: In peak mode, each later sample replaces the low lane only if it is strictly below it, and replaces the high lane only if it is strictly above it. An equal byte changes neither lane.
- R7: A save strobe in cycle t puts the lane values on min_o/max_o with pair_vld_o high for exactly one cycle, two clocks later. The values reflect every sample converted before cycle t. min_o and max_o do not change at any other time.
- R8: A sample converted in the same cycle as a save strobe is the first sample of the new period. It does not take part in the closing pair.
- R9: Reset clears both lanes and outputs to 0x00 and holds pair_vld_o low. The first save strobe after reset only opens a period and emits no pair.
- R10: After a save strobe with no coincident sample, the next converted sample is treated as the first sample of the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_en_i | input | 1 | Convert strobe, one byte per high cycle |
| save_en_i | input | 1 | Save-period boundary strobe |
| mode_i | input | 2 | Acquisition mode: 00 sampling, 01 X-Y, 10 peak, 11 as sampling |
| test_i | input | 1 | Selects diag_i in place of adc_i |
| adc_i | input | DW | Converter byte |
| diag_i | input | DW | Diagnostic byte from the host |
| min_o | output | DW | Low lane value of the last closed period |
| max_o | output | DW | High lane value of the last closed period |
| pair_vld_o | output | 1 | One-cycle pulse when min_o/max_o are fresh |

## Verification
Equal bytes in peak mode are checked because an implementation using non-strict comparison would rewrite the lanes, and one that inverts a comparison would corrupt the emitted peaks. The bytes 0x00 and 0xFF are checked to expose comparisons that wrap or lose a bit. Samples that land on the same cycle as a save strobe are checked because an implementation with the wrong boundary priority would push the new seed into the closing pair. X-Y periods of odd length are checked because an implementation that restarts the channel phase on every save would swap the channels. A converted byte right before a save is checked because dropping the update stage would leave that byte out of the pair.

// File: rtl/peak_cap_pkg.sv
package peak_cap_pkg;
  typedef enum logic [1:0] {
    MODE_SAMP = 2'b00,
    MODE_XY   = 2'b01,
    MODE_PEAK = 2'b10,
    MODE_RSV  = 2'b11
  } acq_mode_e;
endpackage

// File: rtl/peak_src_stage.sv
module peak_src_stage #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          conv_en_i,
  input  logic          save_en_i,
  input  logic          test_i,
  input  logic [DW-1:0] adc_i,
  input  logic [DW-1:0] diag_i,
  output logic [DW-1:0] smp_o,
  output logic          smp_vld_o,
  output logic          smp_first_o
);
  logic          pend_q;
  logic [DW-1:0] bus_d;

  assign bus_d = test_i ? diag_i : adc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o       <= '0;
      smp_vld_o   <= 1'b0;
      smp_first_o <= 1'b0;
      pend_q      <= 1'b1;
    end else begin
      smp_vld_o <= conv_en_i;
      if (conv_en_i) begin
        smp_o       <= bus_d;
        // boundary coinciding with a sample makes it the seed of the new period
        smp_first_o <= save_en_i | pend_q;
        pend_q      <= 1'b0;
      end else if (save_en_i) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/peak_cmp.sv
module peak_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  output logic          lower_o,
  output logic          higher_o
);
  assign lower_o  = smp_i < lo_i;
  assign higher_o = smp_i > hi_i;
endmodule

// File: rtl/peak_reg_bank.sv
module peak_reg_bank
  import peak_cap_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          smp_vld_i,
  input  logic          smp_first_i,
  input  logic [DW-1:0] smp_i,
  input  logic          lower_i,
  input  logic          higher_i,
  output logic [DW-1:0] min_o,
  output logic [DW-1:0] max_o
);
  localparam int NLANE = 2;

  acq_mode_e        mode;
  logic             is_peak, is_xy;
  logic             phase_q, eff_phase;
  logic [NLANE-1:0] ld;
  logic [DW-1:0]    lane_q [NLANE];

  assign mode = acq_mode_e'(mode_i);

  always_comb begin
    is_peak   = (mode == MODE_PEAK);
    is_xy     = (mode == MODE_XY);
    eff_phase = is_xy ? phase_q : (smp_first_i ? 1'b0 : phase_q);
    if (is_peak) begin
      ld[0] = smp_first_i | lower_i;
      ld[1] = smp_first_i | higher_i;
    end else begin
      ld[0] = ~eff_phase;
      ld[1] = eff_phase;
    end
    ld = ld & {NLANE{smp_vld_i}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    phase_q <= 1'b0;
    else if (smp_vld_i && !is_peak) phase_q <= ~eff_phase;
  end

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lane_q[i] <= '0;
      else if (ld[i]) lane_q[i] <= smp_i;
    end
  end

  assign min_o = lane_q[0];
  assign max_o = lane_q[1];
endmodule

// File: rtl/peak_out_stage.sv
module peak_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          save_en_i,
  input  logic [DW-1:0] min_i,
  input  logic [DW-1:0] max_i,
  output logic [DW-1:0] min_o,
  output logic [DW-1:0] max_o,
  output logic          pair_vld_o
);
  logic armed_q, fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      fire_q     <= 1'b0;
      min_o      <= '0;
      max_o      <= '0;
      pair_vld_o <= 1'b0;
    end else begin
      if (save_en_i) armed_q <= 1'b1;
      fire_q     <= save_en_i & armed_q;
      pair_vld_o <= fire_q;
      // lanes at this edge hold every sample converted before the strobe
      if (fire_q) begin
        min_o <= min_i;
        max_o <= max_i;
      end
    end
  end
endmodule

// File: rtl/peak_capture.sv
module peak_capture #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          conv_en_i,
  input  logic          save_en_i,
  input  logic [1:0]    mode_i,
  input  logic          test_i,
  input  logic [DW-1:0] adc_i,
  input  logic [DW-1:0] diag_i,
  output logic [DW-1:0] min_o,
  output logic [DW-1:0] max_o,
  output logic          pair_vld_o
);
  logic [DW-1:0] smp_w, lo_w, hi_w;
  logic          smp_vld_w, smp_first_w, lower_w, higher_w;

  peak_src_stage #(.DW(DW)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_en_i   (conv_en_i),
    .save_en_i   (save_en_i),
    .test_i      (test_i),
    .adc_i       (adc_i),
    .diag_i      (diag_i),
    .smp_o       (smp_w),
    .smp_vld_o   (smp_vld_w),
    .smp_first_o (smp_first_w)
  );

  peak_cmp #(.DW(DW)) u_cmp (
    .smp_i    (smp_w),
    .lo_i     (lo_w),
    .hi_i     (hi_w),
    .lower_o  (lower_w),
    .higher_o (higher_w)
  );

  peak_reg_bank #(.DW(DW)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .smp_vld_i   (smp_vld_w),
    .smp_first_i (smp_first_w),
    .smp_i       (smp_w),
    .lower_i     (lower_w),
    .higher_i    (higher_w),
    .min_o       (lo_w),
    .max_o       (hi_w)
  );

  peak_out_stage #(.DW(DW)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .save_en_i  (save_en_i),
    .min_i      (lo_w),
    .max_i      (hi_w),
    .min_o      (min_o),
    .max_o      (max_o),
    .pair_vld_o (pair_vld_o)
  );
endmodule

// File: rtl/peak_capture_chk.sv
module peak_capture_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          conv_en_i,
  input logic          save_en_i,
  input logic [1:0]    mode_i,
  input logic          test_i,
  input logic [DW-1:0] diag_i,
  input logic [DW-1:0] smp_q,
  input logic          smp_vld_q,
  input logic          smp_first_q,
  input logic [DW-1:0] lo_q,
  input logic [DW-1:0] hi_q,
  input logic [DW-1:0] min_o,
  input logic [DW-1:0] max_o,
  input logic          pair_vld_o
);
  AST_TEST_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_en_i && test_i) |=> (smp_q == $past(diag_i))); // R2

  AST_SEED_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_q && smp_first_q && mode_i == 2'b10) |=> (lo_q == hi_q)); // R5

  AST_LO_NOINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_q && !smp_first_q && mode_i == 2'b10) |=> (lo_q <= $past(lo_q))); // R6

  AST_HI_NODEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_q && !smp_first_q && mode_i == 2'b10) |=> (hi_q >= $past(hi_q))); // R6

  AST_EQ_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_q && !smp_first_q && mode_i == 2'b10 && smp_q >= lo_q && smp_q <= hi_q)
      |=> ($stable(lo_q) && $stable(hi_q))); // R6

  AST_VLD_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_vld_o |-> $past(save_en_i, 2)); // R7

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_vld_o |-> ($stable(min_o) && $stable(max_o))); // R7
endmodule

bind peak_capture peak_capture_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_en_i   (conv_en_i),
  .save_en_i   (save_en_i),
  .mode_i      (mode_i),
  .test_i      (test_i),
  .diag_i      (diag_i),
  .smp_q       (smp_w),
  .smp_vld_q   (smp_vld_w),
  .smp_first_q (smp_first_w),
  .lo_q        (lo_w),
  .hi_q        (hi_w),
  .min_o       (min_o),
  .max_o       (max_o),
  .pair_vld_o  (pair_vld_o)
);

// File: tb/sim_peak_capture.sv
`timescale 1ns/1ps
module sim_peak_capture;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          conv_en = 1'b0, save_en = 1'b0, test_en = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [DW-1:0] adc = '0, diag = '0;
  logic [DW-1:0] min_o, max_o;
  logic          pair_vld_o;

  always #2.5 clk = ~clk;

  peak_capture #(.DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .conv_en_i(conv_en), .save_en_i(save_en),
    .mode_i(mode), .test_i(test_en), .adc_i(adc), .diag_i(diag),
    .min_o(min_o), .max_o(max_o), .pair_vld_o(pair_vld_o)
  );

  int unsigned n_chk = 0, n_fail = 0;
  string       cur_req = "R7";

  // reference model
  logic [DW-1:0] m_lo = '0, m_hi = '0;
  logic          m_phase = 1'b0, m_pend = 1'b1, m_armed = 1'b0;
  logic [2*DW-1:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && pair_vld_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL %s: actual unexpected pair %0h/%0h expected none", cur_req, min_o, max_o);
      end else begin
        logic [2*DW-1:0] e;
        e = exp_q.pop_front();
        chk(cur_req, {min_o, max_o}, e);
      end
    end
  end

  task automatic step(input bit conv, input bit save, input logic [DW-1:0] b);
    logic first;
    conv_en = conv; save_en = save;
    if (test_en) begin diag = b; adc = ~b; end
    else         begin adc = b;  diag = ~b; end
    if (save) begin
      if (m_armed) exp_q.push_back({m_lo, m_hi});
      m_armed = 1'b1;
      m_pend  = 1'b1;
    end
    if (conv) begin
      first  = m_pend;
      m_pend = 1'b0;
      if (mode == 2'b10) begin
        if (first) begin m_lo = b; m_hi = b; end
        else begin
          if (b < m_lo) m_lo = b;
          if (b > m_hi) m_hi = b;
        end
      end else begin
        logic ph;
        ph = (mode == 2'b01) ? m_phase : (first ? 1'b0 : m_phase);
        if (!ph) m_lo = b; else m_hi = b;
        m_phase = ~ph;
      end
    end
    @(negedge clk);
  endtask

  task automatic flush(input string req);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 8'h00);
    chk(req, exp_q.size(), 0);
  endtask

  task automatic t_reset;
    cur_req = "R9";
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", min_o, 0);
    chk("R9", max_o, 0);
    chk("R9", pair_vld_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    step(1, 0, 8'h33); step(1, 0, 8'h44); step(0, 1, 8'h00);
    flush("R9");
  endtask

  task automatic t_sampling(input logic [1:0] md, input string req);
    cur_req = req; mode = md;
    step(0, 0, 0);
    step(1, 1, 8'h11); step(1, 0, 8'h22); step(1, 0, 8'h33);
    step(1, 0, 8'h44); step(1, 0, 8'h55);
    step(0, 1, 8'h00);                        // R1: 0x55 converted just before
    step(1, 0, 8'hA0); step(0, 0, 0); step(1, 0, 8'hB0); step(1, 0, 8'hC0);
    step(0, 1, 8'h00);
    flush(req);
  endtask

  task automatic t_xy;
    cur_req = "R4"; mode = 2'b01;
    step(0, 0, 0);
    for (int p = 0; p < 4; p++) begin
      step(1, 1, 8'(8'h10 + p * 3));
      step(1, 0, 8'(8'h11 + p * 3));
      step(1, 0, 8'(8'h12 + p * 3));
    end
    step(0, 1, 0);
    flush("R4");
  endtask

  task automatic t_peak_rand;
    cur_req = "R6"; mode = 2'b10;
    step(0, 0, 0);
    for (int p = 0; p < 20; p++) begin
      int len;
      len = 4 + int'($urandom_range(8));
      for (int s = 0; s < len; s++) begin
        logic [DW-1:0] b;
        int r;
        r = int'($urandom_range(15));
        b = (r == 0) ? 8'h00 : (r == 1) ? 8'hFF : 8'($urandom);
        step(1, (s == 0), b);
        if ($urandom_range(3) == 0) step(0, 0, 0);
      end
    end
    step(0, 1, 0);
    flush("R6");
  endtask

  task automatic t_equal;
    cur_req = "R5"; mode = 2'b10;
    step(0, 0, 0);
    step(1, 1, 8'h80);                        // R5 seed both
    step(1, 0, 8'h80); step(1, 0, 8'h80); step(1, 0, 8'h80);
    step(0, 1, 0);
    cur_req = "R6";
    step(1, 0, 8'h40); step(1, 0, 8'h90); step(1, 0, 8'h40);
    step(1, 0, 8'h90); step(1, 0, 8'h60);
    step(0, 1, 0);
    flush("R6");
  endtask

  task automatic t_extremes;
    cur_req = "R6"; mode = 2'b10;
    step(0, 0, 0);
    step(1, 1, 8'h7F); step(1, 0, 8'h00); step(1, 0, 8'hFF);
    step(1, 0, 8'h00); step(1, 0, 8'hFF);
    step(1, 1, 8'hFF); step(1, 0, 8'hFF); step(1, 0, 8'hFF); step(1, 0, 8'hFF);
    step(1, 1, 8'h00); step(1, 0, 8'h00); step(1, 0, 8'h00); step(1, 0, 8'h01);
    step(0, 1, 0);
    flush("R6");
  endtask

  task automatic t_boundary;
    cur_req = "R8"; mode = 2'b10;
    step(0, 0, 0);
    step(1, 1, 8'h50); step(1, 0, 8'h51); step(1, 0, 8'h52); step(1, 0, 8'h53);
    step(1, 1, 8'h00);                        // R8 coincident extreme seed
    step(1, 0, 8'h05); step(1, 0, 8'h06); step(1, 0, 8'h07);
    cur_req = "R10";
    step(0, 1, 0);                            // R10 save alone
    step(0, 0, 0); step(0, 0, 0);
    step(1, 0, 8'hF0); step(1, 0, 8'hF1); step(1, 0, 8'hF2); step(1, 0, 8'hF3);
    step(0, 1, 0);
    flush("R10");
  endtask

  task automatic t_test;
    cur_req = "R2"; mode = 2'b10; test_en = 1'b1;
    step(0, 0, 0);
    step(1, 1, 8'h21); step(1, 0, 8'h09); step(1, 0, 8'hE3); step(1, 0, 8'h30);
    step(0, 1, 0);
    test_en = 1'b0;
    step(1, 0, 8'h44); step(1, 0, 8'h45); step(1, 0, 8'h46); step(1, 0, 8'h47);
    step(0, 1, 0);
    flush("R2");
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(150_000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sampling(2'b00, "R3");
    t_sampling(2'b11, "R3");
    t_sampling(2'b00, "R1");
    t_xy();
    t_equal();
    t_extremes();
    t_boundary();
    t_test();
    t_peak_rand();
    cur_req = "R7";
    flush("R7");
    summary();
  end
endmodule